// File: doc/BRIEF.md
# Banked Per-Core Timer Router

This block holds one private countdown timer per processor core and makes them reachable through a set of equal-sized register windows on a single request port. The lowest window is shared. Every core uses the same addresses there, and the router picks the timer from the core-ID that travels with the request. Each higher window is tied to one fixed timer, so any core can inspect or program a neighbour's timer. Each timer drives its own interrupt output.

A request is presented for one cycle with `req_valid`. The router decodes the window and the register offset, checks the access format, and sends a write strobe to at most one timer. One cycle later it returns the read data and an error flag. The error flag is raised when the access names a core that is not configured or when the access is not a full aligned 32-bit word. The core count `NUM_CORES` must lie between 1 and 4, and elaboration stops on any other value.

Top module: `mpt_banked_timers`

## Requirements
- R1: Each window is 0x20 bytes and the window index is `req_addr[ADDR_W-1:5]`. Window 0 routes to the timer numbered by `req_core`, and window k (k ≥ 1) routes to the timer of core k-1, whatever the value of `req_core`.
- R2: An access through window 0 with `req_core` ≥ `NUM_CORES` returns `rsp_err`=1 and `rsp_rdata`=0, and it writes no timer.
- R3: An access through window k ≥ 1 with k-1 ≥ `NUM_CORES` returns `rsp_err`=1 and `rsp_rdata`=0, and it writes no timer.
- R4: Only full words are accepted, meaning `req_be`=4'hF and `req_addr[1:0]`=0. Any other access returns `rsp_err`=1 and `rsp_rdata`=0, and it writes no timer.
- R5: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. A read returns the register value as it stood in the request cycle. When no request was made, `rsp_err` and `rsp_rdata` are 0.
- R6: At most one timer receives a write strobe in any cycle, and only the routed timer receives it.
- R7: The window offsets hold four registers. 0x00 is the reload value, and writing it also sets the count. 0x04 is the count. 0x08 is the control register: bit 0 is run, bit 1 is auto-reload, and bits 15:8 are the prescale P. 0x0C holds the expiry flag in bit 0, and writing a 1 there clears it. Offsets 0x10 to 0x1C read as 0 without error and ignore writes.
- R8: While running with a nonzero count, the count drops by one every P+1 cycles. Once a run starts, the interrupt rises exactly L·(P+1) cycles after the starting write, where L is the count. `irq_out[i]` follows timer i's expiry flag.
- R9: On expiry the count reloads from the reload value if auto-reload is set. Otherwise it stays at 0 and counting stops.
- R10: A control write that turns run on from off, with auto-reload set and a count of 0, loads the count from the reload value. Without auto-reload the count stays 0.
- R11: Synchronous reset clears every timer register, every interrupt output and the response outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_core | input | 2 | Core-ID of the requester |
| req_addr | input | ADDR_W | Byte address (window and offset) |
| req_be | input | 4 | Byte enables; only 4'hF is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was rejected |
| rsp_rdata | output | 32 | Read data, zero on writes and errors |
| irq_out | output | NUM_CORES | Interrupt of each core's timer |

## Verification
The assertions check the routing and response properties on every cycle. These cover the one-cycle response timing, quiet outputs when idle, the single write strobe, error and zero data for out-of-range cores, windows and malformed accesses, and the cleared outputs after reset. Some behaviours only the bench's scenarios can show. These are that the right timer answers for every pairing of core-ID and window, that writes land in that timer and nowhere else, the exact expiry cycle for a chosen prescale, and the reload, one-shot, start-reload and flag-clear behaviour of the counter.

// File: rtl/mpt_pkg.sv
package mpt_pkg;
  localparam int MAX_CORES = 4;
  localparam int CID_W     = 2;
  localparam int DATA_W    = 32;
  localparam int OFS_W     = 5;   // 0x20-byte windows
  localparam int SEL_W     = 3;   // word index inside a window
  localparam int PS_W      = 8;
  localparam int PS_LSB    = 8;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_AUTO = 1;

  typedef enum logic [SEL_W-1:0] {
    SEL_RELOAD = 3'd0,
    SEL_COUNT  = 3'd1,
    SEL_CTRL   = 3'd2,
    SEL_FLAG   = 3'd3
  } reg_sel_e;

  typedef struct packed {
    logic             hit;
    logic             err;
    logic [CID_W-1:0] tgt;
  } route_t;
endpackage

// File: rtl/mpt_decode.sv
module mpt_decode
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 8
) (
  input  logic              req_valid,
  input  logic [CID_W-1:0]  req_core,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  output route_t            route,
  output logic [SEL_W-1:0]  sel
);
  localparam int WIN_W = ADDR_W - OFS_W;

  logic [WIN_W-1:0] win;
  logic             fmt_ok;
  logic             in_range;
  int unsigned      idx;

  assign win = req_addr[ADDR_W-1:OFS_W];
  assign sel = req_addr[OFS_W-1:2];

  always_comb begin
    fmt_ok = (req_be == 4'hF) && (req_addr[1:0] == 2'b00);
    if (win == '0) idx = int'(req_core);
    else           idx = int'(win) - 1;
    in_range  = idx < NUM_CORES;
    route.tgt = CID_W'(idx);
    route.hit = req_valid && fmt_ok && in_range;
    route.err = req_valid && !(fmt_ok && in_range);
  end
endmodule

// File: rtl/mpt_timer.sv
module mpt_timer
  import mpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [DATA_W-1:0] reload_q, count_q;
  logic              run_q, auto_q, flag_q;
  logic [PS_W-1:0]   presc_q, ps_q;
  logic              active, tick;

  assign active = run_q && (count_q != '0);
  assign tick   = active && (ps_q == presc_q);
  assign irq    = flag_q;

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_RELOAD: rdata = reload_q;
      SEL_COUNT:  rdata = count_q;
      SEL_CTRL: begin
        rdata[CTRL_RUN]               = run_q;
        rdata[CTRL_AUTO]              = auto_q;
        rdata[PS_LSB +: PS_W]         = presc_q;
      end
      SEL_FLAG:   rdata[0] = flag_q;
      default:    rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      count_q  <= '0;
      run_q    <= 1'b0;
      auto_q   <= 1'b0;
      flag_q   <= 1'b0;
      presc_q  <= '0;
      ps_q     <= '0;
    end else begin
      if (active) ps_q <= tick ? '0 : ps_q + 1'b1;
      if (tick) begin
        if (count_q == 32'd1) begin
          flag_q  <= 1'b1;
          count_q <= auto_q ? reload_q : '0;
        end else begin
          count_q <= count_q - 1'b1;
        end
      end
      // a bus write takes priority over the same-cycle countdown
      if (wr_en) begin
        case (sel)
          SEL_RELOAD: begin
            reload_q <= wdata;
            count_q  <= wdata;
            ps_q     <= '0;
          end
          SEL_COUNT: begin
            count_q <= wdata;
            ps_q    <= '0;
          end
          SEL_CTRL: begin
            run_q   <= wdata[CTRL_RUN];
            auto_q  <= wdata[CTRL_AUTO];
            presc_q <= wdata[PS_LSB +: PS_W];
            ps_q    <= '0;
            if (!run_q && wdata[CTRL_RUN] && wdata[CTRL_AUTO] && count_q == '0)
              count_q <= reload_q;
          end
          SEL_FLAG: if (wdata[0]) flag_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpt_resp.sv
module mpt_resp
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 2
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req_valid,
  input  logic                               req_write,
  input  route_t                             route,
  input  logic [NUM_CORES-1:0][DATA_W-1:0]   tmr_rdata,
  output logic                               rsp_valid,
  output logic                               rsp_err,
  output logic [DATA_W-1:0]                  rsp_rdata
);
  logic [DATA_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_CORES; i++)
      if (route.hit && !req_write && route.tgt == CID_W'(i)) pick = tmr_rdata[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= route.err;
      rsp_rdata <= pick;
    end
  end
endmodule

// File: rtl/mpt_banked_timers.sv
module mpt_banked_timers
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [CID_W-1:0]     req_core,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [3:0]           req_be,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_CORES-1:0] irq_out
);
  localparam bit CFG_OK = (NUM_CORES >= 1) && (NUM_CORES <= MAX_CORES) &&
                          ((1 << (ADDR_W - OFS_W)) > NUM_CORES);

  generate
    if (!CFG_OK) begin : g_cfg_bad
      $error("mpt_banked_timers: NUM_CORES must be 1..4 with room for its windows");
    end
  endgenerate

  route_t                           route;
  logic [SEL_W-1:0]                 sel;
  logic [NUM_CORES-1:0]             wr_stb;
  logic [NUM_CORES-1:0][DATA_W-1:0] tmr_rdata;

  mpt_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_decode (
    .req_valid (req_valid),
    .req_core  (req_core),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .route     (route),
    .sel       (sel)
  );

  for (genvar i = 0; i < NUM_CORES; i++) begin : g_core
    assign wr_stb[i] = route.hit && req_write && (route.tgt == CID_W'(i));

    mpt_timer u_timer (
      .clk   (clk),
      .rst   (rst),
      .wr_en (wr_stb[i]),
      .sel   (sel),
      .wdata (req_wdata),
      .rdata (tmr_rdata[i]),
      .irq   (irq_out[i])
    );
  end

  mpt_resp #(.NUM_CORES(NUM_CORES)) u_resp (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .route     (route),
    .tmr_rdata (tmr_rdata),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/mpt_banked_timers_chk.sv
module mpt_banked_timers_chk
  import mpt_pkg::*;
#(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       req_valid,
  input logic [CID_W-1:0]           req_core,
  input logic [ADDR_W-OFS_W-1:0]    chk_win,
  input logic [1:0]                 chk_lo,
  input logic [3:0]                 req_be,
  input logic [NUM_CORES-1:0]       wr_stb,
  input logic                       rsp_valid,
  input logic                       rsp_err,
  input logic [DATA_W-1:0]          rsp_rdata,
  input logic [NUM_CORES-1:0]       irq_out
);
  logic alias_bad, direct_bad, fmt_bad;
  assign alias_bad  = req_valid && (chk_win == '0) && (int'(req_core) >= NUM_CORES);
  assign direct_bad = req_valid && (chk_win != '0) && (int'(chk_win) - 1 >= NUM_CORES);
  assign fmt_bad    = req_valid && ((req_be != 4'hF) || (chk_lo != 2'b00));

  // R5
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_err && rsp_rdata == '0));
  // R6
  one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_stb));
  // R2
  alias_oob_chk: assert property (@(posedge clk) disable iff (rst)
    alias_bad |=> (rsp_err && rsp_rdata == '0));
  // R2
  alias_oob_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    alias_bad |-> (wr_stb == '0));
  // R3
  direct_oob_chk: assert property (@(posedge clk) disable iff (rst)
    direct_bad |=> (rsp_err && rsp_rdata == '0));
  // R3
  direct_oob_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    direct_bad |-> (wr_stb == '0));
  // R4
  fmt_reject_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_bad |=> (rsp_err && rsp_rdata == '0));
  // R4
  fmt_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    fmt_bad |-> (wr_stb == '0));
  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && !rsp_valid && !rsp_err));
endmodule

bind mpt_banked_timers mpt_banked_timers_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_core  (req_core),
  .chk_win   (req_addr[ADDR_W-1:5]),
  .chk_lo    (req_addr[1:0]),
  .req_be    (req_be),
  .wr_stb    (wr_stb),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .irq_out   (irq_out)
);

// File: tb/mpt_banked_timers_tb.sv
module mpt_banked_timers_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write;
  logic [1:0]  req_core;
  logic [7:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [NC-1:0] irq_out;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] mdl [NC];

  always #(CLK_PERIOD/2) clk = ~clk;

  mpt_banked_timers #(.NUM_CORES(NC), .ADDR_W(8)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_core(req_core), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .irq_out(irq_out)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] core, input logic [7:0] addr,
                        input logic [3:0] be, input logic [31:0] wd,
                        output logic [31:0] rd, output logic er, output logic vld);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_core = core;
    req_addr = addr; req_be = be; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; er = rsp_err; vld = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd_word(input logic [1:0] core, input logic [7:0] addr, output logic [31:0] rd);
    logic e, v;
    access(1'b0, core, addr, 4'hF, 32'h0, rd, e, v);
  endtask

  task automatic wr_word(input logic [1:0] core, input logic [7:0] addr, input logic [31:0] wd);
    logic [31:0] d; logic e, v;
    access(1'b1, core, addr, 4'hF, wd, d, e, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d; logic e, v;
    int n;
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_core = '0;
    req_addr = '0; req_be = '0; req_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R11 reset state
    check(rsp_valid == 1'b0, "R11 rsp_valid", 32'(rsp_valid), 32'h0);
    check(irq_out == '0, "R11 irq", 32'(irq_out), 32'h0);
    for (int k = 0; k < NC; k++)
      for (int r = 0; r < 4; r++) begin
        rd_word(2'd0, 8'((k + 1) * 32 + r * 4), d);
        check(d == 32'h0, "R11 reg after reset", d, 32'h0);
      end

    // R1 seed reloads through direct windows
    for (int k = 0; k < NC; k++) begin
      mdl[k] = 32'h1000 + 32'(k) * 32'h11;
      wr_word(2'd3, 8'((k + 1) * 32), mdl[k]);
    end

    // R1 R2 R3 R5 read sweep: every core-ID against every window
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 8; w++) begin
        int idx;
        idx = (w == 0) ? c : w - 1;
        access(1'b0, 2'(c), 8'(w * 32), 4'hF, 32'h0, d, e, v);
        check(v == 1'b1, "R5 rsp_valid", 32'(v), 32'h1);
        if (idx < NC) begin
          check(e == 1'b0 && d == mdl[idx], "R1 routed read", d, mdl[idx]);
        end else if (w == 0) begin
          check(e == 1'b1 && d == 32'h0, "R2 alias out of range", {31'h0, e} ^ d, 32'h1);
        end else begin
          check(e == 1'b1 && d == 32'h0, "R3 direct out of range", {31'h0, e} ^ d, 32'h1);
        end
      end
    @(negedge clk);
    check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R5 idle response", 32'(rsp_valid), 32'h0);

    // R6 R2 R3 write sweep: only the routed timer changes
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 8; w++) begin
        int idx;
        logic [31:0] wv;
        idx = (w == 0) ? c : w - 1;
        wv = 32'hA000 + 32'(w * 16 + c);
        access(1'b1, 2'(c), 8'(w * 32), 4'hF, wv, d, e, v);
        if (idx < NC) mdl[idx] = wv;
        check(e == (idx >= NC), "R6 write error flag", 32'(e), 32'(idx >= NC));
        for (int k = 0; k < NC; k++) begin
          rd_word(2'd0, 8'((k + 1) * 32), d);
          check(d == mdl[k], "R6 write lands only in target", d, mdl[k]);
        end
      end

    // R7 reload write also set the count
    rd_word(2'd0, 8'h44, d);
    check(d == mdl[1], "R7 count follows reload write", d, mdl[1]);

    // R4 malformed accesses
    access(1'b1, 2'd0, 8'h20, 4'h3, 32'hDEAD, d, e, v);
    check(e == 1'b1, "R4 partial strobe error", 32'(e), 32'h1);
    access(1'b1, 2'd0, 8'h21, 4'hF, 32'hBEEF, d, e, v);
    check(e == 1'b1, "R4 misaligned write error", 32'(e), 32'h1);
    rd_word(2'd0, 8'h20, d);
    check(d == mdl[0], "R4 writes ignored", d, mdl[0]);
    access(1'b0, 2'd0, 8'h22, 4'hF, 32'h0, d, e, v);
    check(e == 1'b1 && d == 32'h0, "R4 misaligned read", d, 32'h0);

    // R7 unused offsets and control readback
    access(1'b1, 2'd0, 8'h30, 4'hF, 32'hFFFF_FFFF, d, e, v);
    check(e == 1'b0, "R7 unused write no error", 32'(e), 32'h0);
    access(1'b0, 2'd0, 8'h30, 4'hF, 32'h0, d, e, v);
    check(e == 1'b0 && d == 32'h0, "R7 unused offset reads zero", d, 32'h0);
    rd_word(2'd0, 8'h28, d);
    check(d == 32'h0, "R7 ctrl untouched", d, 32'h0);
    rd_word(2'd0, 8'h2C, d);
    check(d == 32'h0, "R7 flag untouched", d, 32'h0);
    wr_word(2'd0, 8'h48, 32'h0000_0502);
    rd_word(2'd0, 8'h48, d);
    check(d == 32'h0000_0502, "R7 ctrl readback", d, 32'h502);
    wr_word(2'd0, 8'h48, 32'h0);

    // R8 expiry cycle, L=5 P=2, one-shot on core 1
    wr_word(2'd0, 8'h40, 32'd5);
    wr_word(2'd0, 8'h48, 32'h0000_0201);
    n = 0;
    while (irq_out[1] == 1'b0 && n < 100) begin
      @(negedge clk); n++;
    end
    check(n == 15, "R8 expiry after L*(P+1) cycles", 32'(n), 32'd15);
    check(irq_out[0] == 1'b0, "R8 other core irq quiet", 32'(irq_out[0]), 32'h0);
    rd_word(2'd0, 8'h44, d);
    check(d == 32'h0, "R9 one-shot stays at zero", d, 32'h0);
    rd_word(2'd0, 8'h4C, d);
    check(d == 32'h1, "R7 flag set", d, 32'h1);
    wr_word(2'd0, 8'h4C, 32'h1);
    check(irq_out[1] == 1'b0, "R7 flag cleared by write 1", 32'(irq_out[1]), 32'h0);

    // R10 start without auto-reload keeps zero, with it loads reload
    wr_word(2'd0, 8'h48, 32'h0);
    wr_word(2'd0, 8'h48, 32'h0000_FF01);
    rd_word(2'd0, 8'h44, d);
    check(d == 32'h0, "R10 no reload without auto", d, 32'h0);
    wr_word(2'd0, 8'h48, 32'h0);
    wr_word(2'd0, 8'h48, 32'h0000_FF03);
    rd_word(2'd0, 8'h44, d);
    check(d == 32'd5, "R10 start reload", d, 32'd5);
    wr_word(2'd0, 8'h48, 32'h0);

    // R9 auto-reload on core 0 through the alias window
    wr_word(2'd0, 8'h00, 32'd3);
    wr_word(2'd0, 8'h08, 32'h0000_0003);
    n = 0;
    while (irq_out[0] == 1'b0 && n < 100) begin
      @(negedge clk); n++;
    end
    check(n == 3, "R8 alias timer expiry", 32'(n), 32'd3);
    rd_word(2'd0, 8'h04, d);
    check(d != 32'h0 && d <= 32'd3, "R9 count reloaded", d, 32'd3);
    check(irq_out[1] == 1'b0, "R1 alias did not touch core 1", 32'(irq_out[1]), 32'h0);

    // R11 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check(irq_out == '0, "R11 irq cleared", 32'(irq_out), 32'h0);
    rd_word(2'd0, 8'h00, d);
    check(d == 32'h0, "R11 reload cleared", d, 32'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule